// File: doc/BRIEF.md
# AUX Request Framer and Reply Decoder

This block sits between a display link controller's transaction layer and the byte-serial engine that drives the auxiliary channel. A caller presents one request: a 20-bit target address, a 4-bit request code and a payload length. The block screens the request, then sends a 4-byte header followed, for writes, by the payload bytes on a valid/ready transmit stream. Reads send the header only. When the lower layer finishes, it returns a status code and a reply byte. For reads it also returns a stream of received bytes. The block forwards received bytes up to the requested length. It then reports a one-cycle completion carrying a result kind, a byte count and the reply code.

Only one transaction is in flight at a time. A busy flag covers the whole interval from acceptance to completion, and no new request is taken while it is set.

All three streams follow the usual rules. A byte moves on a clock edge where both valid and ready are high. The transmit side holds its valid and data steady while ready is low. The payload input is taken only when the transmit side is taking a byte. The forwarded read stream passes on the downstream ready as its own input ready. Received bytes past the requested length are accepted and dropped at once.

Top module: `aux_xact_engine`

## Requirements
- R1: Header byte 0 carries address bits [7:0] and header byte 1 carries address bits [15:8].
- R2: Header byte 2 has the request code in bits [7:4] and address bits [19:16] in bits [3:0].
- R3: Bits [3:0] of header byte 3 hold the length minus one, or 0 when the length is zero.
- R4: Bits [7:4] of header byte 3 depend on the request. A zero-length request gives 3. A read gives 4. A write gives the low four bits of 4 plus the length, so a 16-byte write gives 4.
- R5: A write sends the header and then the payload in input order. A read, and any zero-length request, sends the header only. tx_last marks the final byte.
- R6: A length above 16 completes in the next cycle with kind 4 (too long) and count 0. No transmit byte is sent.
- R7: Bit 0 of the request code selects read (1) or write (0), and bit 2 is the middle-of-transfer flag. After bit 2 is cleared, codes other than 0, 1, 8 and 9 complete in the next cycle with kind 5 (invalid request) and send nothing. The length check of R6 comes first.
- R8: A reply status of 1, 2 or 3 completes with kind 1 (timeout), 2 (flags not zero) or 3 (error) respectively, with count 0 and reply code 0.
- R9: A reply status of 0 completes with kind 0, and the reply code is bits [7:4] of the reply byte.
- R10: A successful write reports its requested length as the count. A successful read forwards at most the requested number of received bytes and reports how many it forwarded. Extra bytes are accepted (rx_ready high) and dropped (dat_valid low).
- R11: busy rises the cycle after a request is accepted and falls the cycle after the one-cycle done_valid pulse. req_ready is low whenever busy is high.
- R12: While tx_valid is high and tx_ready is low, tx_valid and tx_data hold in the next cycle.
- R13: After reset the block is idle: req_ready high, busy, tx_valid, dat_valid and done_valid low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this cycle |
| req_addr | input | 20 | Target address |
| req_code | input | 4 | Request code |
| req_len | input | 5 | Payload length in bytes |
| pl_valid | input | 1 | Write payload byte valid |
| pl_ready | output | 1 | Write payload byte taken |
| pl_data | input | 8 | Write payload byte |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit byte taken |
| tx_data | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the request |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | Received byte taken |
| rx_data | input | 8 | Received byte |
| dat_valid | output | 1 | Forwarded read byte valid |
| dat_ready | input | 1 | Forwarded read byte taken |
| dat_data | output | 8 | Forwarded read byte |
| rply_valid | input | 1 | Reply status present (sampled while waiting) |
| rply_status | input | 2 | Reply status code |
| rply_byte | input | 8 | Raw reply byte |
| busy | output | 1 | Transaction outstanding |
| done_valid | output | 1 | One-cycle completion pulse |
| done_kind | output | 3 | Result kind (0 ok, 1 timeout, 2 flags, 3 error, 4 too long, 5 invalid) |
| done_count | output | 5 | Bytes written or bytes received |
| done_reply | output | 4 | Reply code |

## Verification
The assertions assume the caller plays by the protocol. It raises rply_valid only after the header, and any write payload, has gone out. It never raises rply_valid in the same cycle as a received byte. It offers received bytes only for an outstanding request. The bench keeps to these rules by sequencing each transaction strictly: request, then transmit drain, then received bytes, then reply. The transmit side is stalled on a fixed pattern so that back-pressure is exercised without breaking that ordering.

// File: rtl/aux_xact_pkg.sv
package aux_xact_pkg;
  localparam int AUX_ADDR_W   = 20;
  localparam int AUX_CODE_W   = 4;
  localparam int AUX_HDR_B    = 4;
  localparam int AUX_BARE_SZ  = 3;
  localparam int AUX_MOT_BIT  = 2;

  typedef enum logic [2:0] {
    RES_OK      = 3'd0,
    RES_TIMEOUT = 3'd1,
    RES_FLAGS   = 3'd2,
    RES_IOERR   = 3'd3,
    RES_TOOBIG  = 3'd4,
    RES_BADREQ  = 3'd5
  } res_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HDR, ST_PAY, ST_WAIT, ST_DONE
  } xact_st_e;
endpackage

// File: rtl/aux_hdr_pack.sv
module aux_hdr_pack
  import aux_xact_pkg::*;
#(
  parameter int LEN_W = 5
) (
  input  logic [AUX_ADDR_W-1:0] addr,
  input  logic [AUX_CODE_W-1:0] code,
  input  logic [LEN_W-1:0]      len,
  input  logic                  is_read,
  output logic [AUX_HDR_B-1:0][7:0] hdr
);
  logic [LEN_W:0] total;
  logic [3:0]     lo_nib, hi_nib;

  always_comb begin
    total  = (LEN_W+1)'(AUX_HDR_B) + (is_read ? '0 : {1'b0, len});
    lo_nib = (len == '0) ? 4'd0 : 4'(len - 1'b1);
    hi_nib = (len == '0) ? 4'(AUX_BARE_SZ) : total[3:0];
    hdr[0] = addr[7:0];
    hdr[1] = addr[15:8];
    hdr[2] = {code, addr[19:16]};
    hdr[3] = {hi_nib, lo_nib};
  end
endmodule

// File: rtl/aux_req_check.sv
module aux_req_check
  import aux_xact_pkg::*;
#(
  parameter int LEN_W   = 5,
  parameter int MAX_LEN = 16
) (
  input  logic [AUX_CODE_W-1:0] code,
  input  logic [LEN_W-1:0]      len,
  output logic                  is_read,
  output res_kind_e             verdict
);
  logic [AUX_CODE_W-1:0] base;

  always_comb begin
    base = code;
    base[AUX_MOT_BIT] = 1'b0;
    is_read = code[0];
    if (int'(len) > MAX_LEN)
      verdict = RES_TOOBIG;
    else if (base == 4'h0 || base == 4'h1 || base == 4'h8 || base == 4'h9)
      verdict = RES_OK;
    else
      verdict = RES_BADREQ;
  end
endmodule

// File: rtl/aux_rply_map.sv
module aux_rply_map
  import aux_xact_pkg::*;
(
  input  logic [1:0] status,
  input  logic [3:0] reply_hi,
  output res_kind_e  kind,
  output logic [3:0] code
);
  always_comb begin
    unique case (status)
      2'd1:    kind = RES_TIMEOUT;
      2'd2:    kind = RES_FLAGS;
      2'd3:    kind = RES_IOERR;
      default: kind = RES_OK;
    endcase
    code = (status == 2'd0) ? reply_hi : 4'd0;
  end
endmodule

// File: rtl/aux_xact_engine.sv
module aux_xact_engine
  import aux_xact_pkg::*;
#(
  parameter  int MAX_LEN = 16,
  localparam int LEN_W   = $clog2(MAX_LEN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic [AUX_ADDR_W-1:0] req_addr,
  input  logic [AUX_CODE_W-1:0] req_code,
  input  logic [LEN_W-1:0]      req_len,
  input  logic                  pl_valid,
  output logic                  pl_ready,
  input  logic [7:0]            pl_data,
  output logic                  tx_valid,
  input  logic                  tx_ready,
  output logic [7:0]            tx_data,
  output logic                  tx_last,
  input  logic                  rx_valid,
  output logic                  rx_ready,
  input  logic [7:0]            rx_data,
  output logic                  dat_valid,
  input  logic                  dat_ready,
  output logic [7:0]            dat_data,
  input  logic                  rply_valid,
  input  logic [1:0]            rply_status,
  input  logic [7:0]            rply_byte,
  output logic                  busy,
  output logic                  done_valid,
  output logic [2:0]            done_kind,
  output logic [LEN_W-1:0]      done_count,
  output logic [3:0]            done_reply
);
  localparam int IDX_W = $clog2(AUX_HDR_B);

  xact_st_e               st;
  logic [AUX_ADDR_W-1:0]  addr_q;
  logic [AUX_CODE_W-1:0]  code_q;
  logic [LEN_W-1:0]       len_q, cnt;
  logic                   rd_q;
  logic [IDX_W-1:0]       idx;
  res_kind_e              kind_q;
  logic [LEN_W-1:0]       count_q;
  logic [3:0]             reply_q;

  logic                   chk_read;
  res_kind_e              chk_verdict, map_kind;
  logic [3:0]             map_code;
  logic [AUX_HDR_B-1:0][7:0] hdr;
  logic                   has_pay, hdr_end, pay_end, fwd_ok;
  logic                   unused_rply_lo;

  assign unused_rply_lo = ^rply_byte[3:0];

  aux_req_check #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) u_check (
    .code(req_code), .len(req_len), .is_read(chk_read), .verdict(chk_verdict)
  );

  aux_hdr_pack #(.LEN_W(LEN_W)) u_hdr (
    .addr(addr_q), .code(code_q), .len(len_q), .is_read(rd_q), .hdr(hdr)
  );

  aux_rply_map u_map (
    .status(rply_status), .reply_hi(rply_byte[7:4]), .kind(map_kind), .code(map_code)
  );

  always_comb begin
    has_pay   = !rd_q && (len_q != '0);
    hdr_end   = (idx == IDX_W'(AUX_HDR_B - 1));
    pay_end   = (cnt == LEN_W'(len_q - 1'b1));
    fwd_ok    = (st == ST_WAIT) && rd_q && (cnt < len_q);
    req_ready = (st == ST_IDLE);
    busy      = (st != ST_IDLE);
    tx_valid  = (st == ST_HDR) || ((st == ST_PAY) && pl_valid);
    tx_data   = (st == ST_HDR) ? hdr[idx] : pl_data;
    tx_last   = ((st == ST_HDR) && hdr_end && !has_pay) || ((st == ST_PAY) && pay_end);
    pl_ready  = (st == ST_PAY) && tx_ready;
    dat_valid = fwd_ok && rx_valid;
    dat_data  = rx_data;
    rx_ready  = (st == ST_WAIT) && (fwd_ok ? dat_ready : 1'b1);
    done_valid = (st == ST_DONE);
    done_kind  = kind_q;
    done_count = count_q;
    done_reply = reply_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      code_q  <= '0;
      len_q   <= '0;
      rd_q    <= 1'b0;
      idx     <= '0;
      cnt     <= '0;
      kind_q  <= RES_OK;
      count_q <= '0;
      reply_q <= '0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          addr_q <= req_addr;
          code_q <= req_code;
          len_q  <= req_len;
          rd_q   <= chk_read;
          idx    <= '0;
          cnt    <= '0;
          if (chk_verdict != RES_OK) begin
            kind_q  <= chk_verdict;
            count_q <= '0;
            reply_q <= '0;
            st      <= ST_DONE;
          end else begin
            st <= ST_HDR;
          end
        end
        ST_HDR: if (tx_ready) begin
          idx <= idx + 1'b1;
          if (hdr_end) st <= has_pay ? ST_PAY : ST_WAIT;
        end
        ST_PAY: if (pl_valid && tx_ready) begin
          if (pay_end) begin
            cnt <= '0;
            st  <= ST_WAIT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_WAIT: begin
          if (dat_valid && dat_ready) cnt <= cnt + 1'b1;
          if (rply_valid) begin
            kind_q  <= map_kind;
            reply_q <= map_code;
            count_q <= (map_kind != RES_OK) ? '0 : (rd_q ? cnt : len_q);
            st      <= ST_DONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/aux_xact_checker.sv
module aux_xact_checker #(
  parameter int MAX_LEN = 16,
  parameter int LEN_W   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [3:0]       req_code,
  input logic [LEN_W-1:0] req_len,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic [7:0]       tx_data,
  input logic             rx_valid,
  input logic             dat_valid,
  input logic             busy,
  input logic             done_valid,
  input logic [2:0]       done_kind,
  input logic [LEN_W-1:0] done_count,
  input logic [3:0]       done_reply
);
  logic [3:0] base_code;
  logic       code_ok;
  always_comb begin
    base_code = req_code & 4'b1011;
    code_ok   = (base_code == 4'h0) || (base_code == 4'h1) ||
                (base_code == 4'h8) || (base_code == 4'h9);
  end

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  assert_busy_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && !busy);

  assert_too_long_R6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (int'(req_len) > MAX_LEN) |=>
      done_valid && done_kind == 3'd4 && !tx_valid);

  assert_bad_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && (int'(req_len) <= MAX_LEN) && !code_ok |=>
      done_valid && done_kind == 3'd5 && !tx_valid);

  assert_fail_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid && done_kind >= 3'd1 && done_kind <= 3'd3 |->
      done_count == '0 && done_reply == 4'd0);

  assert_fwd_in_xact_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dat_valid |-> rx_valid && busy);
endmodule

bind aux_xact_engine aux_xact_checker #(.MAX_LEN(MAX_LEN), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_code(req_code), .req_len(req_len), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .rx_valid(rx_valid), .dat_valid(dat_valid), .busy(busy),
  .done_valid(done_valid), .done_kind(done_kind), .done_count(done_count),
  .done_reply(done_reply)
);

// File: tb/aux_xact_engine_test.sv
module aux_xact_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_ready;
  logic [19:0] req_addr = '0;
  logic [3:0]  req_code = '0;
  logic [4:0]  req_len = '0;
  logic pl_valid = 0, pl_ready;
  logic [7:0] pl_data = '0;
  logic tx_valid, tx_ready = 0, tx_last;
  logic [7:0] tx_data;
  logic rx_valid = 0, rx_ready;
  logic [7:0] rx_data = '0;
  logic dat_valid, dat_ready = 0;
  logic [7:0] dat_data;
  logic rply_valid = 0;
  logic [1:0] rply_status = '0;
  logic [7:0] rply_byte = '0;
  logic busy, done_valid;
  logic [2:0] done_kind;
  logic [4:0] done_count;
  logic [3:0] done_reply;

  int checks = 0, failures = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  aux_xact_engine uut (.*);

  // fields: addr, code, len, status, reply byte, received bytes offered
  localparam logic [43:0] VECS [10] = '{
    {20'h12345, 4'h8, 5'd3,  2'd0, 8'h00, 5'd0},
    {20'hABCDE, 4'h9, 5'd5,  2'd0, 8'h20, 5'd5},
    {20'h0F00F, 4'h5, 5'd2,  2'd0, 8'h10, 5'd4},
    {20'h00050, 4'h4, 5'd0,  2'd0, 8'h00, 5'd0},
    {20'hFFFFF, 4'h8, 5'd16, 2'd0, 8'h30, 5'd0},
    {20'h60000, 4'h9, 5'd0,  2'd0, 8'hC5, 5'd0},
    {20'h00A11, 4'h1, 5'd4,  2'd1, 8'hF0, 5'd0},
    {20'h3C3C3, 4'h0, 5'd2,  2'd2, 8'h80, 5'd0},
    {20'h77777, 4'h9, 5'd8,  2'd3, 8'h40, 5'd0},
    {20'h11111, 4'hD, 5'd4,  2'd0, 8'hE7, 5'd1}
  };

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_hdr(input logic [19:0] a, input logic [3:0] c,
                                         input int n, input int i);
    int hi;
    case (i)
      0: return a[7:0];
      1: return a[15:8];
      2: return {c, a[19:16]};
      default: begin
        if (n == 0) hi = 3;
        else if (c[0]) hi = 4;
        else hi = (4 + n) % 16;
        return {4'(hi), (n == 0) ? 4'd0 : 4'(n - 1)};
      end
    endcase
  endfunction

  function automatic logic [7:0] pay(input int v, input int i);
    return 8'(v * 16 + i * 7 + 3);
  endfunction

  task automatic run_vec(input int v);
    logic [19:0] a; logic [3:0] c; int n, st, nrx; logic [7:0] rb;
    logic [7:0] txb [24];
    int got, pidx, dgot, exp_tx, exp_cnt;
    bit fin;
    a = VECS[v][43:24]; c = VECS[v][23:20]; n = int'(VECS[v][19:15]);
    st = int'(VECS[v][14:13]); rb = VECS[v][12:5]; nrx = int'(VECS[v][4:0]);
    exp_tx = (c[0] || n == 0) ? 4 : 4 + n;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_code = c; req_len = 5'(n);
    @(negedge clk);
    req_valid = 0;
    got = 0; pidx = 0; fin = 0;
    for (int cyc = 0; cyc < 200 && !fin; cyc++) begin
      tx_ready = (cyc % 3 != 2);
      pl_valid = !c[0] && (pidx < n);
      pl_data  = pay(v, pidx);
      #1;
      if (tx_valid && tx_ready) begin
        if (got < 24) txb[got] = tx_data;
        got++;
        if (pl_ready) pidx++;
        if (tx_last) fin = 1;
      end
      @(negedge clk);
    end
    tx_ready = 0; pl_valid = 0;
    chk(got == exp_tx, $sformatf("R5 tx byte count vec%0d", v), got, exp_tx);
    for (int i = 0; i < exp_tx && i < got; i++) begin
      logic [7:0] e;
      e = (i < 4) ? exp_hdr(a, c, n, i) : pay(v, i - 4);
      chk(txb[i] == e, $sformatf("R1 R2 R3 R4 R5 tx byte %0d vec%0d", i, v), txb[i], e);
    end
    #1;
    chk(busy && !req_ready, $sformatf("R11 busy while waiting vec%0d", v), busy, 1);
    dgot = 0;
    for (int i = 0; i < nrx; i++) begin
      rx_valid = 1; rx_data = 8'hA0 + 8'(i); dat_ready = 1;
      #1;
      chk(rx_ready, $sformatf("R10 rx_ready byte %0d vec%0d", i, v), rx_ready, 1);
      if (dat_valid) begin
        chk(dat_data == rx_data, $sformatf("R10 fwd data vec%0d", v), dat_data, rx_data);
        dgot++;
      end
      @(negedge clk);
    end
    rx_valid = 0; dat_ready = 0;
    if (c[0])
      chk(dgot == ((nrx < n) ? nrx : n), $sformatf("R10 fwd count vec%0d", v), dgot,
          (nrx < n) ? nrx : n);
    rply_valid = 1; rply_status = 2'(st); rply_byte = rb;
    @(negedge clk);
    rply_valid = 0;
    #1;
    exp_cnt = (st != 0) ? 0 : (c[0] ? ((nrx < n) ? nrx : n) : n);
    chk(done_valid, $sformatf("R11 done pulse vec%0d", v), done_valid, 1);
    chk(int'(done_kind) == st, $sformatf("R8 R9 kind vec%0d", v), done_kind, st);
    chk(int'(done_count) == exp_cnt, $sformatf("R10 count vec%0d", v), done_count, exp_cnt);
    chk(done_reply == ((st == 0) ? rb[7:4] : 4'd0), $sformatf("R9 reply vec%0d", v),
        done_reply, (st == 0) ? rb[7:4] : 4'd0);
    @(negedge clk); #1;
    chk(!busy && req_ready, $sformatf("R11 idle after done vec%0d", v), busy, 0);
  endtask

  task automatic run_err(input logic [3:0] c, input int n, input int kind, input string tag);
    bit saw_tx;
    @(negedge clk);
    req_valid = 1; req_addr = 20'h2468A; req_code = c; req_len = 5'(n); tx_ready = 1;
    #1; saw_tx = tx_valid;
    @(negedge clk);
    req_valid = 0;
    #1; saw_tx = saw_tx | tx_valid;
    chk(done_valid && int'(done_kind) == kind, tag, done_kind, kind);
    chk(done_count == 0, {tag, " count"}, done_count, 0);
    @(negedge clk); #1; saw_tx = saw_tx | tx_valid;
    chk(!saw_tx && !busy, {tag, " no tx"}, saw_tx, 0);
    tx_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(req_ready && !busy && !tx_valid && !dat_valid && !done_valid,
        "R13 reset state", {req_ready, busy, tx_valid, dat_valid, done_valid}, 5'b10000);
    rst_n = 1;
    for (int v = 0; v < 10; v++) run_vec(v);
    run_err(4'h8, 17, 4, "R6 length 17 rejected");
    run_err(4'hA, 31, 4, "R6 length 31 over bad code");
    run_err(4'h2, 3,  5, "R7 code 2 invalid");
    run_err(4'hE, 0,  5, "R7 code E invalid");
    run_vec(1);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule